// File: doc/BRIEF.md
# Lane-Sliced SECDED Read Decoder

This block sits on the read return path of a memory that stores its words with extended Hamming protection. Each incoming beat holds eight independent 39-bit codewords, one per lane. Each lane carries 32 data bits, six Hamming check bits and one overall parity bit. The block turns the beat back into a 256-bit data beat. It repairs any single flipped bit inside a lane and reports when a lane has a double error that cannot be repaired.

The beat flows through a valid/ready stream with no storage. Decoding is purely combinational, so data, flags and handshake all settle in the same cycle as the input. An enable input turns correction and error reporting on or off. When enable is low, the data bits are extracted unchanged. The two error flags are beat-level summaries meant to feed error counters elsewhere.

Top module: `secded_read_decoder`

## Requirements
- R1: Lane k occupies in_data[39k+38:39k] and returns its data on out_data[32k+31:32k]. Codeword bit 0 is the overall parity bit. Codeword bit p (1..38) is Hamming position p. Data bit j is taken from the j-th position, counted in ascending order, that is not a power of two (3, 5, 6, 7, 9, ...).
- R2: out_valid follows in_valid and in_ready follows out_ready in the same cycle.
- R3: A lane whose codeword is error free returns exactly the encoded data.
- R4: With enable high, a single flipped bit at any Hamming position 1..38 is corrected. The syndrome is the XOR of the indices of the set positions. The beat reports sec.
- R5: A flip of the parity bit alone (zero syndrome, odd overall parity) counts as sec and leaves the data unchanged.
- R6: A nonzero syndrome with even overall parity is a double error and reports ded. A syndrome above 38 with odd parity is also reported as ded. In both cases no bit is changed.
- R7: sec and ded are combined across all lanes. If any lane has a double error, the beat raises ded and drops sec.
- R8: While in_valid is low, sec and ded are 0 whatever in_data holds.
- R9: While enable is low, no correction is applied, data is extracted raw, and sec and ded are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Incoming beat is valid |
| in_ready | output | 1 | Upstream may advance (mirrors out_ready) |
| in_data | input | 312 | Eight 39-bit codewords |
| enable | input | 1 | Turns correction and error flags on |
| out_valid | output | 1 | Decoded beat is valid (mirrors in_valid) |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 256 | Eight decoded 32-bit words |
| sec | output | 1 | A correctable error was seen in the beat |
| ded | output | 1 | An uncorrectable error was seen in the beat |

## Verification
The assertions assume the inputs are settled, two-state values when they are evaluated. They also assume that any lane whose syndrome is flagged single points inside the 38 Hamming positions. The bench keeps to this by changing inputs only just after a rising edge and sampling at the falling edge. Its random stimulus corrupts each lane by at most two distinct bits, so the reference model's single/double view is exact. Beyond that, directed beats produce a three-bit pattern whose syndrome falls outside the codeword, which exercises the out-of-range branch.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    LANE_CLEAN  = 2'd0,
    LANE_PARITY = 2'd1,
    LANE_SINGLE = 2'd2,
    LANE_DOUBLE = 2'd3
  } lane_kind_e;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_lane_decoder.sv
module secded_lane_decoder
  import secded_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 6,
  localparam int HAM_W = DATA_W + CHK_W,
  localparam int CW_W  = HAM_W + 1
) (
  input  logic [CW_W-1:0]   cw,
  input  logic              en,
  input  logic              vld,
  output logic [DATA_W-1:0] data,
  output logic              sec_o,
  output logic              ded_o
);

  // XOR of the indices of every set Hamming position
  function automatic logic [CHK_W-1:0] calc_syndrome(input logic [CW_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int i = 1; i <= HAM_W; i++) begin
      if (c[i]) s = s ^ CHK_W'(i);
    end
    return s;
  endfunction

  // Codeword position of the k-th data bit
  function automatic int data_position(input int k);
    int seen;
    seen = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_pow2(p)) begin
        if (seen == k) return p;
        seen++;
      end
    end
    return 0;
  endfunction

  logic [CHK_W-1:0] syndrome;
  logic             par_odd;
  logic             syn_nz;
  logic             syn_in_range;
  lane_kind_e       kind;
  logic [CW_W-1:0]  fix_mask;
  logic [CW_W-1:0]  fixed_cw;

  always_comb begin
    syndrome     = calc_syndrome(cw);
    par_odd      = ^cw;
    syn_nz       = |syndrome;
    syn_in_range = int'(syndrome) <= HAM_W;
  end

  always_comb begin
    if (!syn_nz && !par_odd)            kind = LANE_CLEAN;
    else if (!syn_nz && par_odd)        kind = LANE_PARITY;
    else if (par_odd && syn_in_range)   kind = LANE_SINGLE;
    else                                kind = LANE_DOUBLE;
  end

  always_comb begin
    for (int i = 0; i < CW_W; i++) begin
      fix_mask[i] = en && (kind == LANE_SINGLE) && (int'(syndrome) == i);
    end
    fixed_cw = cw ^ fix_mask;
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_gather
    localparam int DPOS = data_position(k);
    assign data[k] = fixed_cw[DPOS];
  end

  assign sec_o = en && vld && ((kind == LANE_PARITY) || (kind == LANE_SINGLE));
  assign ded_o = en && vld && (kind == LANE_DOUBLE);

  always_comb begin
    assert_single_fix_R4: assert ($countones(fixed_cw ^ cw) <= 1);
    if (!en) begin
      assert_no_fix_disabled_R9: assert (fixed_cw == cw);
    end
    if (kind == LANE_DOUBLE || kind == LANE_PARITY) begin
      assert_no_fix_unrepairable_R6: assert (fixed_cw == cw);
    end
    assert_lane_flags_exclusive_R7: assert (!(sec_o && ded_o));
  end

endmodule

// File: rtl/secded_flag_merge.sv
module secded_flag_merge #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] lane_sec,
  input  logic [LANES-1:0] lane_ded,
  output logic             sec,
  output logic             ded
);

  logic any_sec;
  logic any_ded;

  assign any_sec = |lane_sec;
  assign any_ded = |lane_ded;
  assign ded     = any_ded;
  assign sec     = any_sec && !any_ded;

  always_comb begin
    assert_ded_masks_sec_R7: assert (!(sec && ded));
    if (any_ded) begin
      assert_ded_follows_lane_R7: assert (ded);
    end
  end

endmodule

// File: rtl/secded_read_decoder.sv
module secded_read_decoder
  import secded_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  parameter int CHK_W  = 6,
  localparam int CW_W  = DATA_W + CHK_W + 1,
  localparam int IN_W  = LANES * CW_W,
  localparam int OUT_W = LANES * DATA_W
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             enable,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             sec,
  output logic             ded
);

  logic [LANES-1:0] lane_sec;
  logic [LANES-1:0] lane_ded;

  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    secded_lane_decoder #(
      .DATA_W (DATA_W),
      .CHK_W  (CHK_W)
    ) u_lane (
      .cw    (in_data[g*CW_W +: CW_W]),
      .en    (enable),
      .vld   (in_valid),
      .data  (out_data[g*DATA_W +: DATA_W]),
      .sec_o (lane_sec[g]),
      .ded_o (lane_ded[g])
    );
  end

  secded_flag_merge #(
    .LANES (LANES)
  ) u_merge (
    .lane_sec (lane_sec),
    .lane_ded (lane_ded),
    .sec      (sec),
    .ded      (ded)
  );

  always_comb begin
    if (!in_valid) begin
      assert_idle_quiet_R8: assert (!sec && !ded);
    end
    if (!enable) begin
      assert_disabled_quiet_R9: assert (!sec && !ded);
    end
    assert_beat_flags_exclusive_R7: assert (!(sec && ded));
  end

endmodule

// File: tb/test_secded_read_decoder.sv
module test_secded_read_decoder;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid, in_ready, enable, out_valid, out_ready, sec, ded;
  logic [311:0] in_data;
  logic [255:0] out_data;
  int           n_checks = 0;
  int           n_fail = 0;

  always #10 clk = ~clk;

  secded_read_decoder i_secded_read_decoder (
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .enable (enable), .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data), .sec (sec), .ded (ded)
  );

  function automatic bit pw2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [38:0] enc(input logic [31:0] d);
    logic [38:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) if (!pw2(p)) begin c[p] = d[k]; k++; end
    for (int j = 0; j < 6; j++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p <= 38; p++) if (((p >> j) & 1) == 1 && p != (1 << j)) x ^= c[p];
      c[1 << j] = x;
    end
    c[0] = ^c[38:1];
    return c;
  endfunction

  function automatic logic [31:0] raw(input logic [38:0] c);
    logic [31:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) if (!pw2(p)) begin d[k] = c[p]; k++; end
    return d;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [311:0] d, input logic en, input logic v, input logic r);
    @(posedge clk);
    #1;
    in_data = d; enable = en; in_valid = v; out_ready = r;
    @(negedge clk);
  endtask

  initial begin
    logic [311:0] b;
    in_data = '0; enable = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset / idle state
    drive('0, 1'b1, 1'b0, 1'b0);
    chk("R8 idle sec", 256'(sec), 256'd0);
    chk("R8 idle ded", 256'(ded), 256'd0);
    chk("R2 idle out_valid", 256'(out_valid), 256'd0);

    // bit 1 only, parity clear
    b = '0; b[1] = 1'b1;
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R4 bit1 sec", 256'(sec), 256'd1);
    chk("R4 bit1 ded", 256'(ded), 256'd0);
    chk("R3 bit1 data", out_data, 256'd0);
    chk("R2 valid/ready", 256'({out_valid, in_ready}), 256'd3);
    drive(b, 1'b1, 1'b0, 1'b0);
    chk("R8 bit1 no valid sec", 256'({sec, ded}), 256'd0);
    chk("R2 ready low", 256'({out_valid, in_ready}), 256'd0);

    // enable low: raw extraction, data bit0 sits at position 3
    b = '0; b[3] = 1'b1;
    drive(b, 1'b0, 1'b1, 1'b1);
    chk("R9 disabled flags", 256'({sec, ded}), 256'd0);
    chk("R9 disabled raw data", out_data, 256'd1);
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R4 pos3 corrected", out_data, 256'd0);

    // parity bit alone
    b = '0; b[0] = 1'b1;
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R5 parity sec", 256'({sec, ded}), 256'd2);
    chk("R5 parity data", out_data, 256'd0);

    // syndrome 39 with odd parity
    b = '0; b[0] = 1'b1; b[7] = 1'b1; b[32] = 1'b1;
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R6 out of range ded", 256'({sec, ded}), 256'd1);

    // lane 0 single, lane 3 double
    b = '0; b[5] = 1'b1; b[3*39 + 9] = 1'b1; b[3*39 + 20] = 1'b1;
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R7 ded masks sec", 256'({sec, ded}), 256'd1);
    chk("R6 double untouched lane3", 256'(out_data[127:96]), 256'(raw(b[3*39 +: 39])));

    // lane 5 highest position maps to its top data bit
    b = '0; b[5*39 + 38] = 1'b1;
    drive(b, 1'b0, 1'b1, 1'b1);
    chk("R1 lane layout", out_data, 256'(1) << (5*32 + 31));

    // all-ones data in every lane, lane 7 bit 38 flipped
    for (int l = 0; l < 8; l++) b[l*39 +: 39] = enc(32'hFFFF_FFFF);
    b[7*39 + 38] ^= 1'b1;
    drive(b, 1'b1, 1'b1, 1'b1);
    chk("R4 lane7 top fix", out_data, {256{1'b1}});
    chk("R4 lane7 sec", 256'({sec, ded}), 256'd2);

    // random beats
    for (int it = 0; it < 400; it++) begin
      logic [255:0] exp_d, mask;
      logic en, v, any1, any2;
      en = ($urandom_range(0, 4) != 0);
      v  = ($urandom_range(0, 4) != 0);
      any1 = 1'b0; any2 = 1'b0; mask = '1; exp_d = '0;
      for (int l = 0; l < 8; l++) begin
        logic [31:0] w;
        logic [38:0] c;
        int n, p1, p2;
        w = $urandom;
        c = enc(w);
        n = $urandom_range(0, 2);
        p1 = $urandom_range(0, 38);
        p2 = (p1 + 1 + $urandom_range(0, 37)) % 39;
        if (n >= 1) c[p1] ^= 1'b1;
        if (n == 2) c[p2] ^= 1'b1;
        if (n == 1) any1 = 1'b1;
        if (n == 2) any2 = 1'b1;
        b[l*39 +: 39] = c;
        if (!en) exp_d[l*32 +: 32] = raw(c);
        else if (n <= 1) exp_d[l*32 +: 32] = w;
        else mask[l*32 +: 32] = '0;
      end
      drive(b, en, v, 1'($urandom_range(0, 1)));
      chk("R3 R4 R9 random data", out_data & mask, exp_d & mask);
      chk("R7 R8 random ded", 256'(ded), 256'(en && v && any2));
      chk("R7 R8 random sec", 256'(sec), 256'(en && v && any1 && !any2));
      chk("R2 random handshake", 256'({out_valid, in_ready}), 256'({v, out_ready}));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule